// File: doc/BRIEF.md
# Three-Floor Elevator Controller

This block schedules a car serving three floors. Hall and car calls are captured in two per-floor request registers, one for upward calls and one for downward calls. From these registers and the current floor the block derives three flags: a call at this floor, a call above and a call below. A three-way direction state (waiting, going up, going down) chooses the next move. The car keeps its current heading while calls remain ahead of it, and it turns around only when nothing is left in that direction.

One down-counter, advanced by a one-pulse-per-second enable, times both the trip between adjacent floors and the door-open interval. The close button ends the door interval early. The delay button restarts it. A run switch parks the car: while the switch is low, the car is held at the ground floor and every pending call is dropped. The outputs are a binary floor number for a display decoder, a two-bit direction lamp and a door-open flag.

Top module: `lift3_ctrl`

## Requirements
- R1: While `rstN` is low or `runSw` is 0, the car is at the ground floor (`floorInd` = 1), `dirLamp` = 00, `doorOpen` = 0, and all pending calls are discarded. Once the switch returns to 1, no motion follows from calls made before it dropped.
- R2: Bit i of `upReq`/`dnReq` requests floor i (0 = ground, 2 = top). A pulse of one cycle is latched until that floor is served. An up call for the top floor and a down call for the ground floor are ignored.
- R3: When waiting with the door closed and no call at the current floor, the car starts up if any call is above. Otherwise it starts down if any call is below. Otherwise it stays waiting. An up start wins when calls are both above and below.
- R4: While heading up, the car keeps climbing as long as a call is above it, and switches to down only when none is above and one is below. The same rule applies mirrored while heading down.
- R5: One floor step takes TRAVEL_TICKS enable pulses (default 1). The floor changes by exactly one per step and never leaves the range 0..FLOORS-1.
- R6: The car stops and opens its door at any floor with a pending up or down call. Both calls of that floor are cleared while the door is open, and the floor does not change while the door is open.
- R7: The door stays open for DWELL_LOAD enable pulses (default 6) and then closes.
- R8: A `closeBtn` pulse while the door is open closes it on the next clock edge.
- R9: A `delayBtn` pulse while the door is open restarts the full DWELL_LOAD interval.
- R10: A call at the current floor while waiting opens the door without moving, and the lamp stays 00.
- R11: `dirLamp` is 00 when waiting, 01 heading up and 10 heading down. `floorInd` is the floor index plus one in binary.
- R12: When the door closes and no call remains, the direction returns to waiting (lamp 00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable pulse per second for the timer |
| runSw | input | 1 | Run switch; 0 parks the car at the ground floor |
| closeBtn | input | 1 | Ends the door-open interval |
| delayBtn | input | 1 | Restarts the door-open interval |
| upReq | input | 3 | Upward call per floor (bit = floor index) |
| dnReq | input | 3 | Downward call per floor (bit = floor index) |
| floorInd | output | 4 | Current floor number, 1 to 3 |
| dirLamp | output | 2 | Direction: 00 waiting, 01 up, 10 down |
| doorOpen | output | 1 | Door-open interval in progress |

## Verification
Some properties are checked on every cycle:
- the floor stays in range and moves one step at a time, with no upward step from the top and no downward step from the ground;
- the floor holds while the door is open;
- the close button ends the door interval;
- the switch-off parking takes effect;
- the idle state stays put when no calls are pending;
- a car heading up with calls above continues up.

Other behaviours can only be shown by the directed scenarios:
- the exact dwell and travel lengths in enable pulses, and the restart by the delay button;
- that a served call is really gone;
- that masked top-up and ground-down calls have no effect;
- the full up-then-reverse sequence, with its door openings, under the direction-first rule.

// File: rtl/lift3_pkg.sv
package lift3_pkg;

  typedef enum logic [1:0] {
    DIR_WAIT = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dir_e;

  typedef enum logic [1:0] {
    PH_DECIDE = 2'd0,
    PH_MOVE   = 2'd1,
    PH_DOOR   = 2'd2
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadTravel;
    logic loadDwell;
    logic countEn;
    logic stepUp;
    logic stepDown;
    logic clearHere;
  } strobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic hereCall;
    logic aboveCall;
    logic belowCall;
    logic expire;
  } status_t;

endpackage

// File: rtl/lift3_datapath.sv
module lift3_datapath
  import lift3_pkg::*;
#(
  parameter int FLOORS       = 3,
  parameter int TRAVEL_TICKS = 1,
  parameter int DWELL_LOAD   = 6,
  localparam int FW    = (FLOORS > 1) ? $clog2(FLOORS) : 1,
  localparam int TMAX  = (TRAVEL_TICKS > DWELL_LOAD) ? TRAVEL_TICKS : DWELL_LOAD,
  localparam int TW    = $clog2(TMAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runSw,
  input  logic              tick,
  input  logic [FLOORS-1:0] upReq,
  input  logic [FLOORS-1:0] dnReq,
  input  strobe_t           strobe,
  output status_t           status,
  output logic [FW-1:0]     floorQ
);

  logic [FLOORS-1:0] upRegQ, dnRegQ, pending;
  logic [FLOORS-1:0] hereBits, aboveBits, belowBits;
  logic [TW-1:0]     timerQ;

  // per-floor request storage and position flags
  for (genvar g = 0; g < FLOORS; g++) begin : gFloor
    logic atFloor, clearHit, upOk, dnOk;
    assign atFloor  = (floorQ == FW'(g));
    assign clearHit = strobe.clearHere && atFloor;
    assign upOk     = (g != FLOORS - 1);
    assign dnOk     = (g != 0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        upRegQ[g] <= 1'b0;
        dnRegQ[g] <= 1'b0;
      end else if (!runSw || clearHit) begin
        upRegQ[g] <= 1'b0;
        dnRegQ[g] <= 1'b0;
      end else begin
        upRegQ[g] <= upRegQ[g] | (upReq[g] & upOk);
        dnRegQ[g] <= dnRegQ[g] | (dnReq[g] & dnOk);
      end
    end

    assign pending[g]   = upRegQ[g] | dnRegQ[g];
    assign hereBits[g]  = pending[g] && atFloor;
    assign aboveBits[g] = pending[g] && (FW'(g) > floorQ);
    assign belowBits[g] = pending[g] && (FW'(g) < floorQ);
  end

  // car position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               floorQ <= '0;
    else if (!runSw)         floorQ <= '0;
    else if (strobe.stepUp)  floorQ <= floorQ + FW'(1);
    else if (strobe.stepDown) floorQ <= floorQ - FW'(1);
  end

  // shared travel / dwell timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  timerQ <= '0;
    else if (!runSw)            timerQ <= '0;
    else if (strobe.loadTravel) timerQ <= TW'(TRAVEL_TICKS);
    else if (strobe.loadDwell)  timerQ <= TW'(DWELL_LOAD);
    else if (strobe.countEn && tick && timerQ != '0) timerQ <= timerQ - TW'(1);
  end

  assign status.hereCall  = |hereBits;
  assign status.aboveCall = |aboveBits;
  assign status.belowCall = |belowBits;
  assign status.expire    = tick && (timerQ <= TW'(1));

  // R5
  floor_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(floorQ) < FLOORS);

  // R5
  floor_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(runSw) && floorQ != $past(floorQ)) |->
      (floorQ == $past(floorQ) + FW'(1) || floorQ + FW'(1) == $past(floorQ)));

  // R5
  top_no_climb_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepUp |-> int'(floorQ) != FLOORS - 1);

  // R5
  ground_no_sink_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepDown |-> floorQ != '0);

endmodule

// File: rtl/lift3_control.sv
module lift3_control
  import lift3_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    runSw,
  input  logic    closeBtn,
  input  logic    delayBtn,
  input  status_t status,
  output strobe_t strobe,
  output dir_e    dirQ,
  output logic    doorOpen
);

  phase_e phaseQ, phaseD;
  dir_e   dirD;
  logic   goUp, goDown;

  // direction-first choice: hold heading while calls lie ahead
  assign goUp   = status.aboveCall && (dirQ != DIR_DOWN || !status.belowCall);
  assign goDown = status.belowCall && !goUp;

  always_comb begin
    phaseD = phaseQ;
    dirD   = dirQ;
    strobe = '0;
    if (!runSw) begin
      phaseD = PH_DECIDE;
      dirD   = DIR_WAIT;
    end else begin
      unique case (phaseQ)
        PH_DECIDE: begin
          if (status.hereCall) begin
            phaseD           = PH_DOOR;
            strobe.loadDwell = 1'b1;
          end else if (goUp) begin
            phaseD            = PH_MOVE;
            dirD              = DIR_UP;
            strobe.loadTravel = 1'b1;
          end else if (goDown) begin
            phaseD            = PH_MOVE;
            dirD              = DIR_DOWN;
            strobe.loadTravel = 1'b1;
          end else begin
            dirD = DIR_WAIT;
          end
        end
        PH_MOVE: begin
          if (status.expire) begin
            phaseD          = PH_DECIDE;
            strobe.stepUp   = (dirQ == DIR_UP);
            strobe.stepDown = (dirQ == DIR_DOWN);
          end else begin
            strobe.countEn = 1'b1;
          end
        end
        PH_DOOR: begin
          strobe.clearHere = 1'b1;
          if (closeBtn) begin
            phaseD = PH_DECIDE;
          end else if (delayBtn) begin
            strobe.loadDwell = 1'b1;
          end else if (status.expire) begin
            phaseD = PH_DECIDE;
          end else begin
            strobe.countEn = 1'b1;
          end
        end
        default: phaseD = PH_DECIDE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_DECIDE;
      dirQ   <= DIR_WAIT;
    end else begin
      phaseQ <= phaseD;
      dirQ   <= dirD;
    end
  end

  assign doorOpen = (phaseQ == PH_DOOR);

  // R1
  park_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runSw |=> (dirQ == DIR_WAIT && phaseQ == PH_DECIDE));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runSw && phaseQ == PH_DECIDE && dirQ == DIR_WAIT && !status.hereCall &&
     !status.aboveCall && !status.belowCall) |=>
      (phaseQ == PH_DECIDE && dirQ == DIR_WAIT));

  // R4
  keep_climb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runSw && phaseQ == PH_DECIDE && dirQ == DIR_UP && !status.hereCall &&
     status.aboveCall) |=> (phaseQ == PH_MOVE && dirQ == DIR_UP));

  // R8
  close_cut_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runSw && phaseQ == PH_DOOR && closeBtn) |=> phaseQ != PH_DOOR);

endmodule

// File: rtl/lift3_ctrl.sv
module lift3_ctrl
  import lift3_pkg::*;
#(
  parameter int FLOORS       = 3,
  parameter int TRAVEL_TICKS = 1,
  parameter int DWELL_LOAD   = 6,
  localparam int FW = (FLOORS > 1) ? $clog2(FLOORS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              runSw,
  input  logic              closeBtn,
  input  logic              delayBtn,
  input  logic [FLOORS-1:0] upReq,
  input  logic [FLOORS-1:0] dnReq,
  output logic [3:0]        floorInd,
  output logic [1:0]        dirLamp,
  output logic              doorOpen
);

  strobe_t       strobe;
  status_t       status;
  dir_e          dirQ;
  logic [FW-1:0] floorQ;

  lift3_datapath #(
    .FLOORS(FLOORS), .TRAVEL_TICKS(TRAVEL_TICKS), .DWELL_LOAD(DWELL_LOAD)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .runSw(runSw), .tick(tick),
    .upReq(upReq), .dnReq(dnReq), .strobe(strobe),
    .status(status), .floorQ(floorQ)
  );

  lift3_control control_i (
    .clk(clk), .rstN(rstN), .runSw(runSw), .closeBtn(closeBtn),
    .delayBtn(delayBtn), .status(status), .strobe(strobe),
    .dirQ(dirQ), .doorOpen(doorOpen)
  );

  assign floorInd = 4'(floorQ) + 4'd1;

  always_comb begin
    unique case (dirQ)
      DIR_UP:   dirLamp = 2'b01;
      DIR_DOWN: dirLamp = 2'b10;
      default:  dirLamp = 2'b00;
    endcase
  end

  // R11
  floor_ind_chk: assert property (@(posedge clk) disable iff (!rstN)
    floorInd >= 4'd1 && int'(floorInd) <= FLOORS);

  // R6
  door_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doorOpen && runSw) |=> floorInd == $past(floorInd));

endmodule

// File: tb/lift3_ctrl_tb.sv
module lift3_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       runSw = 1'b1;
  logic       closeBtn = 1'b0;
  logic       delayBtn = 1'b0;
  logic [2:0] upReq = '0;
  logic [2:0] dnReq = '0;
  logic [3:0] floorInd;
  logic [1:0] dirLamp;
  logic       doorOpen;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lift3_ctrl dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .runSw(runSw),
    .closeBtn(closeBtn), .delayBtn(delayBtn), .upReq(upReq), .dnReq(dnReq),
    .floorInd(floorInd), .dirLamp(dirLamp), .doorOpen(doorOpen)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chkState(input string req, input int fl, input int lamp, input int door);
    check(req, "floorInd", int'(floorInd), fl);
    check(req, "dirLamp", int'(dirLamp), lamp);
    check(req, "doorOpen", int'(doorOpen), door);
  endtask

  task automatic pulseTick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    idle(3);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulseTick();
  endtask

  task automatic press(input logic [2:0] up, input logic [2:0] dn);
    @(negedge clk) begin upReq = up; dnReq = dn; end
    @(negedge clk) begin upReq = '0; dnReq = '0; end
    idle(3);
  endtask

  task automatic pushClose();
    @(negedge clk) closeBtn = 1'b1;
    @(negedge clk) closeBtn = 1'b0;
    idle(3);
  endtask

  task automatic pushDelay();
    @(negedge clk) delayBtn = 1'b1;
    @(negedge clk) delayBtn = 1'b0;
    idle(3);
  endtask

  task automatic goHome();
    @(negedge clk) runSw = 1'b0;
    idle(2);
    @(negedge clk) runSw = 1'b1;
    idle(2);
  endtask

  // R1 R11: reset state
  task automatic testReset();
    idle(2);
    chkState("R1", 1, 0, 0);
  endtask

  // R3 R5 R6 R7 R12: trip up to the top floor, then a call below
  task automatic testUpTrip();
    goHome();
    press(3'b000, 3'b100);
    chkState("R3", 1, 1, 0);
    pulseTick();
    chkState("R5", 2, 1, 0);
    pulseTick();
    chkState("R6", 3, 1, 1);
    ticks(5);
    chkState("R7", 3, 1, 1);
    pulseTick();
    chkState("R12", 3, 0, 0);
    ticks(3);
    chkState("R6", 3, 0, 0);   // served call is gone
    press(3'b010, 3'b000);
    chkState("R3", 3, 2, 0);   // below only: start down
    pulseTick();
    chkState("R6", 2, 2, 1);
    pushClose();
    chkState("R8", 2, 0, 0);
  endtask

  // R4: call behind the car waits until the heading is exhausted
  task automatic testDirFirst();
    goHome();
    press(3'b000, 3'b100);
    press(3'b001, 3'b000);
    pulseTick();
    chkState("R4", 2, 1, 0);
    pulseTick();
    chkState("R4", 3, 1, 1);
    pushClose();
    chkState("R4", 3, 2, 0);
    pulseTick();
    chkState("R4", 2, 2, 0);
    pulseTick();
    chkState("R6", 1, 2, 1);
    pushClose();
    chkState("R12", 1, 0, 0);
  endtask

  // R10 R9: call at current floor, then extend the dwell
  task automatic testDelay();
    goHome();
    press(3'b001, 3'b000);
    chkState("R10", 1, 0, 1);
    ticks(3);
    pushDelay();
    ticks(5);
    check("R9", "doorOpen after reload", int'(doorOpen), 1);
    pulseTick();
    check("R9", "doorOpen at reload end", int'(doorOpen), 0);
  endtask

  // R3: calls above and below at once from the middle floor
  task automatic testPriority();
    goHome();
    press(3'b010, 3'b000);
    pulseTick();
    chkState("R6", 2, 1, 1);
    pushClose();
    chkState("R12", 2, 0, 0);
    press(3'b001, 3'b100);
    chkState("R3", 2, 1, 0);
  endtask

  // R2: top-floor up and ground-floor down calls are ignored
  task automatic testMask();
    goHome();
    press(3'b100, 3'b001);
    ticks(2);
    chkState("R2", 1, 0, 0);
  endtask

  // R1: switch off during a trip
  task automatic testRunOff();
    goHome();
    press(3'b000, 3'b100);
    pulseTick();
    chkState("R5", 2, 1, 0);
    @(negedge clk) runSw = 1'b0;
    idle(2);
    chkState("R1", 1, 0, 0);
    @(negedge clk) runSw = 1'b1;
    idle(2);
    ticks(2);
    chkState("R1", 1, 0, 0);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testUpTrip();
    testDirFirst();
    testDelay();
    testPriority();
    testMask();
    testRunOff();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule